// File: doc/BRIEF.md
# Peripheral Interrupt Flag with Access-Sequence Clear

This block holds the interrupt status flag and its enable bit for one peripheral, together with the peripheral's data register. A single-cycle strobe from the peripheral function sets the flag. The request sent to the core is the flag ANDed with its enable bit and then gated by the controller's global mask input. Software reaches three registers through a simple one-cycle read/write bus.

Software can drop the flag in two ways. It can write 0 to the flag bit. It can also touch the status register while the flag is set and then read or write the data register. A small arm state tracks this two-step sequence. Either way of clearing also discards a request that was latched but never enabled.

Register map: address 0 is the status register (flag in bit 0, other bits read 0). Address 1 is the control register (enable in bit 0). Address 2 is the data register (all bits, read/write). Address 3 reads 0.

Top module: `periph_irq_flag`

## Requirements
- R1: After reset the flag, the enable and the data register are 0, irq_o is low, and reads of addresses 0, 1 and 2 return 0.
- R2: An event_i pulse sets the flag, and status bit 0 reads 1 from the following cycle.
- R3: irq_o is high exactly when the flag is set, enable bit 0 of address 1 is set, and mask_i is low. irq_o follows mask_i in the same cycle.
- R4: While the enable bit is clear or mask_i is high, the flag stays set. irq_o rises once both conditions allow it, without a new event.
- R5: A write to address 0 with bit 0 equal to 0 clears the flag from the next cycle.
- R6: A write to address 0 with bit 0 equal to 1 leaves the flag unchanged.
- R7: A read or write of address 0 while the flag is set arms the clear. A later read or write of address 2 then clears the flag. Accesses to address 1 in between do not disarm it.
- R8: An access to address 0 while the flag is clear disarms the clear. A data access after that leaves a newly set flag alone.
- R9: An event in the same cycle as a clearing access (data access while armed, or a status write of 0) wins, and the flag stays set.
- R10: A data register access with no armed status access does not clear the flag.
- R11: A clear by sequence removes a pending request that was never enabled. Setting the enable bit afterwards gives no irq_o.
- R12: The control register stores enable bit 0, and the data register stores and returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| event_i | input | 1 | Peripheral event strobe, sets the flag |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i, combinational |
| mask_i | input | 1 | Global interrupt mask from the controller, 1 = masked |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
A stuck or missing arm state shows up at the ports on the next status read. Either the flag survives a status-then-data sequence that should clear it, or a stray data access wipes a flag that no status access armed. A flag that drops wrongly becomes visible one cycle after the offending access, through the status read and through irq_o once the enable bit is set. The same-cycle event race is driven directly, so a design that gives priority to the clear loses the flag by the next read.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_CTRL   = 2'd1,
    REG_DATA   = 2'd2,
    REG_RSVD   = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_SET  = 1'b1
  } arm_e;

  typedef struct packed {
    logic st_acc;   // status read or write
    logic st_wr;
    logic ctl_wr;
    logic dat_acc;  // data read or write
    logic dat_wr;
  } acc_t;
endpackage

// File: rtl/irqf_bus_dec.sv
module irqf_bus_dec
  import irqf_pkg::*;
(
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output acc_t              acc_o
);
  always_comb begin
    acc_o = '0;
    if (req_i) begin
      unique case (reg_sel_e'(addr_i))
        REG_STATUS: begin
          acc_o.st_acc = 1'b1;
          acc_o.st_wr  = we_i;
        end
        REG_CTRL:   acc_o.ctl_wr = we_i;
        REG_DATA: begin
          acc_o.dat_acc = 1'b1;
          acc_o.dat_wr  = we_i;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqf_clr_fsm.sv
module irqf_clr_fsm
  import irqf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  acc_t acc_i,
  input  logic flag_i,
  input  logic wr_clr_i,
  output logic armed_o,
  output logic seq_clr_o
);
  arm_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (acc_i.st_acc)
      // arm only if the flag survives this status access
      state_d = (flag_i && !wr_clr_i) ? ARM_SET : ARM_IDLE;
    else if (acc_i.dat_acc)
      state_d = ARM_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ARM_IDLE;
    else         state_q <= state_d;
  end

  assign armed_o   = (state_q == ARM_SET);
  assign seq_clr_o = armed_o && acc_i.dat_acc;
endmodule

// File: rtl/irqf_regs.sv
module irqf_regs
  import irqf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int EN_BIT = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  acc_t              acc_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              wr_clr_i,
  input  logic              seq_clr_i,
  output logic              flag_o,
  output logic              en_o,
  output logic [DATA_W-1:0] data_o
);
  logic flag_d;

  // event has priority over both clear paths
  always_comb begin
    flag_d = flag_o;
    if (event_i)                     flag_d = 1'b1;
    else if (wr_clr_i || seq_clr_i)  flag_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      en_o   <= 1'b0;
      data_o <= '0;
    end else begin
      flag_o <= flag_d;
      if (acc_i.ctl_wr) en_o   <= wdata_i[EN_BIT];
      if (acc_i.dat_wr) data_o <= wdata_i;
    end
  end
endmodule

// File: rtl/periph_irq_flag.sv
module periph_irq_flag
  import irqf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int FLAG_BIT = 0,
  parameter int EN_BIT   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              mask_i,
  output logic              irq_o
);
  acc_t              acc;
  logic              wr_clr, seq_clr, armed;
  logic              flag_q, en_q;
  logic [DATA_W-1:0] data_q;

  irqf_bus_dec u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .acc_o (acc)
  );

  assign wr_clr = acc.st_wr && !wdata_i[FLAG_BIT];

  irqf_clr_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .acc_i    (acc),
    .flag_i   (flag_q),
    .wr_clr_i (wr_clr),
    .armed_o  (armed),
    .seq_clr_o(seq_clr)
  );

  irqf_regs #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .event_i  (event_i),
    .acc_i    (acc),
    .wdata_i  (wdata_i),
    .wr_clr_i (wr_clr),
    .seq_clr_i(seq_clr),
    .flag_o   (flag_q),
    .en_o     (en_q),
    .data_o   (data_q)
  );

  always_comb begin
    rdata_o = '0;
    unique case (reg_sel_e'(addr_i))
      REG_STATUS: rdata_o[FLAG_BIT] = flag_q;
      REG_CTRL:   rdata_o[EN_BIT]   = en_q;
      REG_DATA:   rdata_o           = data_q;
      default: ;
    endcase
  end

  assign irq_o = flag_q && en_q && !mask_i;
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic st_acc_i,
  input logic st_wr_i,
  input logic dat_acc_i,
  input logic wflag_i,
  input logic event_i,
  input logic mask_i,
  input logic irq_i,
  input logic flag_i,
  input logic en_i,
  input logic armed_i
);
  p_event_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i |=> flag_i);

  p_mask_blocks_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !irq_i);

  p_irq_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> en_i);

  p_fall_needs_access_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_i) |-> $past(req_i));

  p_wr1_no_effect_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_wr_i && wflag_i && !flag_i && !event_i) |=> !flag_i);

  p_seq_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_i && dat_acc_i && !event_i) |=> !flag_i);

  p_arm_cancel_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_acc_i && !flag_i) |=> !armed_i);

  p_arm_needs_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_i) |-> $past(flag_i));
endmodule

bind periph_irq_flag irqf_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .st_acc_i (acc.st_acc),
  .st_wr_i  (acc.st_wr),
  .dat_acc_i(acc.dat_acc),
  .wflag_i  (wdata_i[FLAG_BIT]),
  .event_i  (event_i),
  .mask_i   (mask_i),
  .irq_i    (irq_o),
  .flag_i   (flag_q),
  .en_i     (en_q),
  .armed_i  (armed)
);

// File: tb/tb_periph_irq_flag.sv
module tb_periph_irq_flag;
  localparam int DW = 8;
  localparam logic [1:0] A_ST = 2'd0, A_CT = 2'd1, A_DA = 2'd2;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          event_i = 1'b0, req_i = 1'b0, we_i = 1'b0, mask_i = 1'b0;
  logic [1:0]    addr_i = '0;
  logic [DW-1:0] wdata_i = '0, rdata_o;
  logic          irq_o;

  int total = 0, bad = 0;
  bit done = 0;

  typedef struct { logic [DW-1:0] exp; string tag; } exp_t;
  exp_t sb_q[$];

  periph_irq_flag dut (.*);

  always #10 clk_i = ~clk_i;  // 50 MHz

  // monitor: compare read data mid-cycle
  always @(negedge clk_i) begin
    if (req_i && !we_i && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (rdata_o !== e.exp) begin
        bad++;
        $display("FAIL %s rdata act=%h exp=%h", e.tag, rdata_o, e.exp);
      end
    end
  end

  task automatic idle();
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0; event_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string tag);
    exp_t e;
    @(posedge clk_i); #1;
    req_i = 1; we_i = 0; addr_i = a; event_i = 0;
    e.exp = exp; e.tag = tag; sb_q.push_back(e);
    idle();
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d, input logic ev);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d; event_i = ev;
    idle();
  endtask

  task automatic rd_ev(input logic [1:0] a);
    @(posedge clk_i); #1;
    req_i = 1; we_i = 0; addr_i = a; event_i = 1;
    idle();
  endtask

  task automatic pulse();
    @(posedge clk_i); #1;
    event_i = 1;
    idle();
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    @(negedge clk_i);
    total++;
    if (irq_o !== exp) begin
      bad++;
      $display("FAIL %s irq act=%b exp=%b", tag, irq_o, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    if (!done) $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R1 reset state
    chk_irq(0, "R1");
    rd(A_ST, 8'h00, "R1 status");
    rd(A_CT, 8'h00, "R1 ctrl");
    rd(A_DA, 8'h00, "R1 data");
    // R2 / R4: latched while disabled
    pulse();
    chk_irq(0, "R4 disabled");
    rd(A_ST, 8'h01, "R2 set");
    wr(A_CT, 8'h01, 0);
    rd(A_CT, 8'h01, "R12 ctrl");
    chk_irq(1, "R4 enabled later");
    @(posedge clk_i); #1 mask_i = 1;
    chk_irq(0, "R3 masked");
    @(posedge clk_i); #1 mask_i = 0;
    chk_irq(1, "R3 unmasked");
    // R6 / R5
    wr(A_ST, 8'h01, 0);
    rd(A_ST, 8'h01, "R6 write one");
    wr(A_ST, 8'h00, 0);
    rd(A_ST, 8'h00, "R5 write zero");
    chk_irq(0, "R5 irq");
    // R10 then R7 (read of data)
    pulse();
    wr(A_DA, 8'h5A, 0);
    rd(A_DA, 8'h5A, "R12 data");
    rd(A_ST, 8'h01, "R10 no arm");
    wr(A_CT, 8'h01, 0);
    rd(A_DA, 8'h5A, "R7 data read");
    rd(A_ST, 8'h00, "R7 read clears");
    chk_irq(0, "R7 irq");
    // R8: status access with flag clear disarms
    rd(A_ST, 8'h00, "R8 disarm");
    pulse();
    rd(A_DA, 8'h5A, "R8 data");
    rd(A_ST, 8'h01, "R8 kept");
    wr(A_DA, 8'h33, 0);
    rd(A_ST, 8'h00, "R7 write clears");
    rd(A_DA, 8'h33, "R12 data2");
    // R9: event races clears
    pulse();
    rd(A_ST, 8'h01, "R9 arm");
    rd_ev(A_DA);
    rd(A_ST, 8'h01, "R9 seq race");
    wr(A_ST, 8'h00, 1);
    rd(A_ST, 8'h01, "R9 wr race");
    wr(A_ST, 8'h00, 0);
    rd(A_ST, 8'h00, "R5 clear again");
    // R11: pending request lost
    wr(A_CT, 8'h00, 0);
    pulse();
    chk_irq(0, "R11 pending");
    rd(A_ST, 8'h01, "R11 arm");
    rd(A_DA, 8'h33, "R11 data");
    wr(A_CT, 8'h01, 0);
    chk_irq(0, "R11 lost");
    rd(A_ST, 8'h00, "R11 status");

    repeat (3) @(posedge clk_i);
    if (sb_q.size() != 0) begin
      bad++; total++;
      $display("FAIL scoreboard act=%0d exp=0 left", sb_q.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule